// File: doc/BRIEF.md
# Escalating Watchdog with Guarded Stop

This block is a watchdog for a processor subsystem. It has a small bank of periodic microsecond timers and a watchdog state machine. A configuration field chooses which timer's expiry pulses the watchdog counts. Software arms the watchdog with a start command and services it by sending the same start command again before too many expiries pile up.

The first expiry that is not serviced can raise an interrupt. If the count of unserviced expiries reaches four, two level reset requests can assert: one for the whole system and one for the clock and reset controller. Each request has its own enable. Because four expiries are needed, software sets the timer period to one quarter of the timeout it wants.

Software cannot simply stop the watchdog. A stop command is honoured only if the unlock register has just been written with a fixed key. The key is spent by the next command write.

Top module: `wdog_escalator`

## Requirements
- R1: Reads return data one cycle after `bus_re`. The configuration word at address 0x00 reads back what was written, masked to bits [3:0], 4, 12, 14 and 15. After reset every register reads zero and every output is low.
- R2: Timer i has a value word at 0x20+8*i: bit 31 is enable, bit 30 is auto-reload, bits [28:0] are the period P. Writing this word loads the countdown with P. Each `tick_us` pulse while enabled decrements the countdown. On the P-th tick an expiry occurs and the countdown reloads with P. Without auto-reload, that expiry also clears bit 31. Writing zero stops the timer.
- R3: Timer i has a control word at 0x24+8*i. It reads the pending flag at bit 30 and the countdown at bits [28:0]. An expiry sets the flag. Writing 1 to bit 30 clears it. `tmr_irq[i]` mirrors the flag.
- R4: Configuration bits [3:0] choose the timer whose expiries the watchdog counts. A value of NUM_TMR or above means no expiries are counted.
- R5: Writing 1 to bit 0 of the command word at 0x08 marks the watchdog running. It also clears the expiry count and the interrupt, whether the watchdog was running or stopped.
- R6: When configuration bit 12 is set, the first counted expiry asserts `wd_irq`. The interrupt stays high until the next start command.
- R7: The fourth counted expiry since the last start asserts `sys_rst_req` if configuration bit 14 is set, and `car_rst_req` if bit 15 is set. Both requests stay high until the block is reset.
- R8: Writing 1 to bit 1 of the command word stops the watchdog and clears its count and interrupt. This happens only if the last write to the unlock word at 0x0C was 0xC45A and no command write has happened since. Any command write, and any other unlock value, drops the unlock. When both command bits are set and the block is unlocked, the stop wins.
- R9: The command word reads the running flag at bit 31 and the expiry count at bits [18:16]. The count saturates at 4. The unlock word reads the unlock state at bit 0.
- R10: With configuration bit 4 clear, the first counted expiry also clears the running flag, so no later expiry is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle microsecond tick shared by all timers |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wd_irq | output | 1 | Watchdog interrupt |
| sys_rst_req | output | 1 | System reset request, sticky |
| car_rst_req | output | 1 | Clock/reset controller reset request, sticky |
| tmr_irq | output | NUM_TMR | Pending flag of each timer |

## Verification
The assertions assume several things about the inputs:
- `bus_we` and `bus_re` are never high in the same cycle.
- Addresses are word aligned and fall on the mapped words.
- `tick_us` is a single-cycle pulse.

The stimulus keeps to these rules. Every access is a one-cycle strobe from a task, each tick is followed by an idle cycle, and only mapped addresses are used. The stimulus never writes a command in the same cycle as a counted expiry, so the checks never depend on that priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;
  localparam int ESC_LEVEL = 4;
  localparam int CNT_W = $clog2(ESC_LEVEL + 1);
  localparam int SEL_W = 4;
  localparam logic [15:0] CFG_MASK = 16'hD01F;
  localparam int CFG_PER_BIT = 4;
  localparam int CFG_IRQ_BIT = 12;
  localparam int CFG_SYS_BIT = 14;
  localparam int CFG_CAR_BIT = 15;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT = 1;
  localparam int TMR_EN_BIT = 31;
  localparam int TMR_RLD_BIT = 30;
  localparam int TMR_CLR_BIT = 30;
  localparam int CMD_RUN_BIT = 31;
  localparam int CMD_CNT_LSB = 16;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             periodic;
    logic             irq_en;
    logic             sys_en;
    logic             car_en;
  } wd_cfg_t;
endpackage

// File: rtl/wdog_tmr.sv
module wdog_tmr #(
  parameter int PERIOD_W = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                val_we,
  input  logic                val_en,
  input  logic                val_rld,
  input  logic [PERIOD_W-1:0] val_period,
  input  logic                clr_we,
  output logic [31:0]         val_q,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                pend_q,
  output logic                expire_q
);
  logic                en_q;
  logic                rld_q;
  logic [PERIOD_W-1:0] period_q;
  logic                hit;

  assign hit = en_q && tick && (cnt_q <= PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      rld_q    <= 1'b0;
      period_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (clr_we) pend_q <= 1'b0;
      if (val_we) begin
        en_q     <= val_en;
        rld_q    <= val_rld;
        period_q <= val_period;
        cnt_q    <= val_period;
      end else if (en_q && tick) begin
        if (hit) begin
          expire_q <= 1'b1;
          pend_q   <= 1'b1;
          cnt_q    <= period_q;
          if (!rld_q) en_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - PERIOD_W'(1);
        end
      end
    end
  end

  always_comb begin
    val_q = '0;
    val_q[31] = en_q;
    val_q[30] = rld_q;
    val_q[PERIOD_W-1:0] = period_q;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  wd_cfg_t          cfg,
  input  logic             cmd_we,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             unlock_we,
  input  logic [15:0]      unlock_data,
  input  logic             exp_in,
  output logic             running_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             irq_q,
  output logic             sys_q,
  output logic             car_q
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(ESC_LEVEL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ESC_LEVEL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      irq_q     <= 1'b0;
      sys_q     <= 1'b0;
      car_q     <= 1'b0;
    end else begin
      if (unlock_we) armed_q <= (unlock_data == UNLOCK_KEY);
      if (cmd_we) begin
        armed_q <= 1'b0;
        if (cmd_stop && armed_q) begin
          running_q <= 1'b0;
          cnt_q     <= '0;
          irq_q     <= 1'b0;
        end else if (cmd_start) begin
          running_q <= 1'b1;
          cnt_q     <= '0;
          irq_q     <= 1'b0;
        end
      end else if (exp_in && running_q) begin
        if (cnt_q < TOP) cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == '0 && cfg.irq_en) irq_q <= 1'b1;
        if (cnt_q == LAST) begin
          if (cfg.sys_en) sys_q <= 1'b1;
          if (cfg.car_en) car_q <= 1'b1;
        end
        if (!cfg.periodic) running_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int NUM_TMR  = 2,
  parameter int ADDR_W   = 6,
  parameter int PERIOD_W = 29
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_us,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               wd_irq,
  output logic               sys_rst_req,
  output logic               car_rst_req,
  output logic [NUM_TMR-1:0] tmr_irq
);
  localparam int TIDX_W = ADDR_W - 4;

  logic              wd_region;
  logic [1:0]        wd_off;
  logic [TIDX_W-1:0] t_idx;
  logic              t_off;
  logic              cfg_we;
  logic              cmd_we;
  logic              unlock_we;
  logic [15:0]       cfg_q;
  wd_cfg_t           cfg;
  logic              sel_pulse;
  logic              running;
  logic [CNT_W-1:0]  exp_cnt;
  logic              armed;

  logic [NUM_TMR-1:0]  t_val_we;
  logic [NUM_TMR-1:0]  t_clr_we;
  logic [NUM_TMR-1:0]  t_exp;
  logic [NUM_TMR-1:0]  t_pend;
  logic [31:0]         t_val [NUM_TMR];
  logic [PERIOD_W-1:0] t_cnt [NUM_TMR];

  assign wd_region = !bus_addr[ADDR_W-1];
  assign wd_off    = bus_addr[3:2];
  assign t_idx     = bus_addr[ADDR_W-2:3];
  assign t_off     = bus_addr[2];
  assign cfg_we    = bus_we && wd_region && (wd_off == 2'd0);
  assign cmd_we    = bus_we && wd_region && (wd_off == 2'd2);
  assign unlock_we = bus_we && wd_region && (wd_off == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q <= bus_wdata[15:0] & CFG_MASK;
  end

  always_comb begin
    cfg.sel      = cfg_q[SEL_W-1:0];
    cfg.periodic = cfg_q[CFG_PER_BIT];
    cfg.irq_en   = cfg_q[CFG_IRQ_BIT];
    cfg.sys_en   = cfg_q[CFG_SYS_BIT];
    cfg.car_en   = cfg_q[CFG_CAR_BIT];
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign t_val_we[g] = bus_we && !wd_region && (t_idx == TIDX_W'(g)) && !t_off;
    assign t_clr_we[g] = bus_we && !wd_region && (t_idx == TIDX_W'(g)) && t_off
                         && bus_wdata[TMR_CLR_BIT];
    wdog_tmr #(.PERIOD_W(PERIOD_W)) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick_us),
      .val_we     (t_val_we[g]),
      .val_en     (bus_wdata[TMR_EN_BIT]),
      .val_rld    (bus_wdata[TMR_RLD_BIT]),
      .val_period (bus_wdata[PERIOD_W-1:0]),
      .clr_we     (t_clr_we[g]),
      .val_q      (t_val[g]),
      .cnt_q      (t_cnt[g]),
      .pend_q     (t_pend[g]),
      .expire_q   (t_exp[g])
    );
  end

  assign tmr_irq = t_pend;

  always_comb begin
    sel_pulse = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (cfg.sel == SEL_W'(i)) sel_pulse = t_exp[i];
    end
  end

  wdog_core u_core (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg),
    .cmd_we      (cmd_we),
    .cmd_start   (bus_wdata[CMD_START_BIT]),
    .cmd_stop    (bus_wdata[CMD_STOP_BIT]),
    .unlock_we   (unlock_we),
    .unlock_data (bus_wdata[15:0]),
    .exp_in      (sel_pulse),
    .running_q   (running),
    .cnt_q       (exp_cnt),
    .armed_q     (armed),
    .irq_q       (wd_irq),
    .sys_q       (sys_rst_req),
    .car_q       (car_rst_req)
  );

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (wd_region) begin
      unique case (wd_off)
        2'd0: rd_next[15:0] = cfg_q;
        2'd2: begin
          rd_next[CMD_RUN_BIT] = running;
          rd_next[CMD_CNT_LSB +: CNT_W] = exp_cnt;
        end
        2'd3: rd_next[0] = armed;
        default: rd_next = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (t_idx == TIDX_W'(i)) begin
          if (!t_off) rd_next = t_val[i];
          else begin
            rd_next[TMR_CLR_BIT] = t_pend[i];
            rd_next[PERIOD_W-1:0] = t_cnt[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sel_pulse,
  input logic             cmd_we,
  input logic             running,
  input logic [CNT_W-1:0] exp_cnt,
  input logic             armed,
  input logic             wd_irq,
  input logic             sys_rst_req,
  input logic             car_rst_req
);
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    exp_cnt <= CNT_W'(ESC_LEVEL));

  assert_sys_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> sys_rst_req);

  assert_car_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    car_rst_req |=> car_rst_req);

  assert_sys_on_fourth_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> ($past(exp_cnt) == CNT_W'(ESC_LEVEL - 1)) && $past(sel_pulse));

  assert_irq_on_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_irq) |-> ($past(exp_cnt) == '0) && $past(sel_pulse));

  assert_unlock_spent_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> !armed);

  assert_stop_guarded_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(cmd_we && armed) || $past(sel_pulse));
endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sel_pulse   (sel_pulse),
  .cmd_we      (cmd_we),
  .running     (running),
  .exp_cnt     (exp_cnt),
  .armed       (armed),
  .wd_irq      (wd_irq),
  .sys_rst_req (sys_rst_req),
  .car_rst_req (car_rst_req)
);

// File: tb/wdog_escalator_bench.sv
module wdog_escalator_bench;
  localparam int NUM_TMR = 2;
  localparam int ADDR_W  = 6;
  localparam logic [5:0] A_CFG = 6'h00, A_CMD = 6'h08, A_UNL = 6'h0C;
  localparam logic [5:0] A_T0V = 6'h20, A_T0C = 6'h24, A_T1V = 6'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic bus_we = 1'b0;
  logic bus_re = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wd_irq, sys_rst_req, car_rst_req;
  logic [NUM_TMR-1:0] tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_escalator #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_wdog_escalator (
    .clk(clk), .rst(rst), .tick_us(tick_us), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_irq(wd_irq), .sys_rst_req(sys_rst_req), .car_rst_req(car_rst_req),
    .tmr_irq(tmr_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd_word(bit run, int cnt);
    return {run, 12'd0, 3'(cnt), 16'd0};
  endfunction

  initial begin
    logic [31:0] d;
    do_reset();
    // R1: reset state and configuration readback
    chk("R1 outputs after reset", {28'd0, wd_irq, sys_rst_req, car_rst_req, |tmr_irq}, 32'd0);
    rd(A_CFG, d); chk("R1 cfg after reset", d, 32'd0);
    rd(A_CMD, d); chk("R1 cmd after reset", d, 32'd0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d); chk("R1 cfg masked readback", d, 32'h0000_D01F);

    // R2 and R3: timer sweep over period, mode and tick count
    for (int p = 1; p <= 4; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int t = 0; t <= 9; t++) begin
          int rem, expc;
          bit exp_pend, exp_en;
          wr(A_T0V, {1'b1, 1'(m), 30'(p)});
          wr(A_T0C, 32'h4000_0000);
          ticks(t);
          exp_pend = (t >= p);
          if (m == 1) begin
            rem = t % p;
            expc = (rem == 0) ? p : p - rem;
            exp_en = 1'b1;
          end else begin
            expc = (t < p) ? p - t : p;
            exp_en = (t < p);
          end
          rd(A_T0V, d);
          chk("R2 timer value word", d, {exp_en, 1'(m), 30'(p)});
          rd(A_T0C, d);
          chk("R3 timer control word", d, {1'b0, exp_pend, 1'b0, 29'(expc)});
          chk("R3 tmr_irq mirrors pending", {31'd0, tmr_irq[0]}, {31'd0, exp_pend});
        end
      end
    end
    wr(A_T0V, 32'h0);
    wr(A_T0C, 32'h4000_0000);
    ticks(4);
    rd(A_T0C, d); chk("R2 zero write stops timer", d, 32'd0);

    // R6 R7 R9: escalation sweep over enables and expiry counts
    for (int c = 0; c < 8; c++) begin
      for (int n = 1; n <= 5; n++) begin
        int ec;
        do_reset();
        wr(A_CFG, 32'h10 | (c[0] ? 32'h1000 : 0) | (c[1] ? 32'h4000 : 0) | (c[2] ? 32'h8000 : 0));
        wr(A_T0V, 32'hC000_0002);
        wr(A_CMD, 32'h1);
        ticks(2 * n);
        ec = (n > 4) ? 4 : n;
        chk("R6 irq after first expiry", {31'd0, wd_irq}, {31'd0, 1'(c[0])});
        chk("R7 system reset request", {31'd0, sys_rst_req}, {31'd0, 1'(c[1] && n >= 4)});
        chk("R7 controller reset request", {31'd0, car_rst_req}, {31'd0, 1'(c[2] && n >= 4)});
        rd(A_CMD, d); chk("R9 running and saturating count", d, cmd_word(1'b1, ec));
      end
    end

    // R5: start command services the watchdog
    do_reset();
    wr(A_CFG, 32'hD010);
    wr(A_T0V, 32'hC000_0001);
    wr(A_CMD, 32'h1);
    ticks(3);
    rd(A_CMD, d); chk("R5 count before kick", d, cmd_word(1'b1, 3));
    wr(A_CMD, 32'h1);
    rd(A_CMD, d); chk("R5 kick clears count", d, cmd_word(1'b1, 0));
    chk("R5 kick clears irq", {31'd0, wd_irq}, 32'd0);
    ticks(3);
    chk("R5 no reset after kick and three expiries", {31'd0, sys_rst_req}, 32'd0);
    ticks(1);
    chk("R7 reset on fourth expiry after kick", {31'd0, sys_rst_req}, 32'd1);

    // R4: source selection
    do_reset();
    wr(A_T0V, 32'hC000_0001);
    wr(A_CFG, 32'h11);
    wr(A_CMD, 32'h1);
    ticks(3);
    rd(A_CMD, d); chk("R4 unselected timer ignored", d, cmd_word(1'b1, 0));
    wr(A_CFG, 32'h15);
    ticks(3);
    rd(A_CMD, d); chk("R4 out-of-range select counts nothing", d, cmd_word(1'b1, 0));
    wr(A_CFG, 32'h11);
    wr(A_T1V, 32'hC000_0001);
    ticks(2);
    rd(A_CMD, d); chk("R4 selected timer one counted", d, cmd_word(1'b1, 2));

    // R8: guarded stop
    do_reset();
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    rd(A_CMD, d); chk("R8 stop without unlock ignored", d, cmd_word(1'b1, 0));
    wr(A_UNL, 32'hC45A);
    rd(A_UNL, d); chk("R9 unlock state reads one", d, 32'd1);
    wr(A_CMD, 32'h2);
    rd(A_CMD, d); chk("R8 stop after unlock honoured", d, cmd_word(1'b0, 0));
    wr(A_CMD, 32'h1);
    wr(A_UNL, 32'hC45A);
    wr(A_CMD, 32'h1);
    rd(A_UNL, d); chk("R8 command write spends unlock", d, 32'd0);
    wr(A_CMD, 32'h2);
    rd(A_CMD, d); chk("R8 stop after spent unlock ignored", d, cmd_word(1'b1, 0));
    wr(A_UNL, 32'h1234);
    wr(A_CMD, 32'h2);
    rd(A_CMD, d); chk("R8 wrong key ignored", d, cmd_word(1'b1, 0));
    wr(A_UNL, 32'hC45A);
    wr(A_UNL, 32'h0000);
    rd(A_UNL, d); chk("R8 other value drops unlock", d, 32'd0);
    wr(A_UNL, 32'hC45A);
    wr(A_CMD, 32'h3);
    rd(A_CMD, d); chk("R8 stop wins over start", d, cmd_word(1'b0, 0));

    // R10: one-shot watchdog mode
    do_reset();
    wr(A_CFG, 32'h1000);
    wr(A_T0V, 32'hC000_0002);
    wr(A_CMD, 32'h1);
    ticks(4);
    rd(A_CMD, d); chk("R10 stops after first expiry", d, cmd_word(1'b0, 1));
    chk("R10 irq raised", {31'd0, wd_irq}, 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule